// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register port. A 32-bit up-counter advances on pulses of a slow time base, optionally divided by a power of two. When it passes its all-ones value, it raises a one-cycle reset request. It then reloads itself from a programmable load register. Software keeps the system alive by writing a fresh value to a trigger register. Any change of that value reloads the counter.

The counter can be started or stopped only by a pair of key words written in the right order. A stray write cannot halt the watchdog. Writes to the registers that feed the slow-timed counter are held in shadow registers. Each one raises a pending flag and takes effect on the next `slow_tick` pulse. A write to a register whose flag is still set is dropped. Two interrupt sources, counter overflow and a programmable compare match, are latched in a status register. A soft-reset bit returns every register to its reset value on the next slow pulse.

The register port has no handshake and no back-pressure. A write takes effect on the clock edge where `bus_sel` and `bus_we` are high. Read data is combinational from `bus_addr`. Addresses are word indices.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the counter reads 0, the pending register reads 0, the timer is stopped, and `irq` and `rst_req` are low.
- R2: The timer starts only after word 0x0000BBBB and then word 0x00004444 are applied to the key register (index 10). Once started, the counter (index 5) advances by one per effective tick. The first tick that can advance it is the one after the tick that applies 0x4444.
- R3: Applying 0x0000AAAA and then 0x00005555 to the key register stops the timer. The counter then holds its value.
- R4: A broken key sequence does not change the run state, and the sequence tracker returns to idle. A broken sequence is a first word followed by any word other than its partner. After 0xAAAA, 0x1234, 0x5555 the timer keeps running.
- R5: The pending register (index 8) has these bits: bit0 prescale, bit1 load, bit2 trigger, bit3 delay, bit4 key. A bit sets on a write to its register and clears on the next `slow_tick`, when the write takes effect. A write to a register whose bit is set is discarded.
- R6: A tick that finds the counter at 0xFFFFFFFF while running loads the counter from the load register (index 6). The same tick pulses `rst_req` high for exactly one clock and sets status bit0 (overflow).
- R7: Applying a trigger value (index 7) different from the current one reloads the counter from the load value. That load value includes a load write applied on the same tick. Applying an equal value does not reload.
- R8: The prescale register (index 4) has bit3 as enable and bits 2:0 as a shift P. With the enable set, the counter advances once every 2^P slow ticks. With it clear, the counter advances on every tick.
- R9: When the counter steps to the value of the delay register (index 9), status bit1 (delay) sets.
- R10: `irq` is high exactly when a status bit (index 2) is set and its enable bit (index 3, bit0 overflow, bit1 delay) is set. Writing 1 to a status bit clears it.
- R11: Writing 1 to bit0 of the control register (index 1) makes that bit read 1 until the next `slow_tick`. At that tick every register returns to its reset value and the bit reads 0.
- R12: The identification register (index 0) always reads the `REV_ID` parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-clock pulse per slow time-base period |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | One-clock reset request on overflow |

## Verification
The bound checker watches every cycle. It checks that the counter and the run state change only on `slow_tick` cycles. It checks that pending flags drop after a tick that carries no new write. It also checks that `rst_req` is a single-cycle pulse that is always followed by a set overflow status bit. The bench scenarios cover the rest. They show the key ordering, dropped writes while a flag is pending, and reload on a changed trigger value only. They also cover the exact overflow reload value, the prescaled step rate, the delay match, the write-one-to-clear behaviour, and the soft reset sequence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] RA_ID     = 4'd0;
  localparam logic [IDX_W-1:0] RA_SYSCTL = 4'd1;
  localparam logic [IDX_W-1:0] RA_ISTAT  = 4'd2;
  localparam logic [IDX_W-1:0] RA_IEN    = 4'd3;
  localparam logic [IDX_W-1:0] RA_PRESC  = 4'd4;
  localparam logic [IDX_W-1:0] RA_COUNT  = 4'd5;
  localparam logic [IDX_W-1:0] RA_LOAD   = 4'd6;
  localparam logic [IDX_W-1:0] RA_TRIG   = 4'd7;
  localparam logic [IDX_W-1:0] RA_PEND   = 4'd8;
  localparam logic [IDX_W-1:0] RA_DELAY  = 4'd9;
  localparam logic [IDX_W-1:0] RA_KEY    = 4'd10;

  localparam int P_PRESC = 0;
  localparam int P_LOAD  = 1;
  localparam int P_TRIG  = 2;
  localparam int P_DELAY = 3;
  localparam int P_KEY   = 4;
  localparam int NPEND   = 5;

  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;
  localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;

  typedef enum logic [1:0] {KS_IDLE, KS_RUN_HALF, KS_HALT_HALF} key_st_t;
endpackage

// File: rtl/wdt_keyfsm.sv
module wdt_keyfsm
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        apply,
  input  logic [31:0] word,
  output logic        running
);
  key_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st      <= KS_IDLE;
      running <= 1'b0;
    end else if (apply) begin
      case (st)
        KS_IDLE: begin
          if (word == KEY_RUN_A)       st <= KS_RUN_HALF;
          else if (word == KEY_HALT_A) st <= KS_HALT_HALF;
          else                         st <= KS_IDLE;
        end
        KS_RUN_HALF: begin
          if (word == KEY_RUN_B) running <= 1'b1;
          st <= KS_IDLE;
        end
        KS_HALT_HALF: begin
          if (word == KEY_HALT_B) running <= 1'b0;
          st <= KS_IDLE;
        end
        default: st <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             step
);
  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [DIV_W-1:0] pre_cnt;
  logic [DIV_W-1:0] limit;
  logic             terminal;

  assign limit    = (DIV_W'(1) << ptv) - DIV_W'(1);
  assign terminal = !pre_en || (pre_cnt == limit);
  assign step     = tick && run && terminal;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run || !pre_en) pre_cnt <= '0;
    else if (tick) pre_cnt <= terminal ? '0 : pre_cnt + DIV_W'(1);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] delay_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             dly_evt
);
  logic [CNT_W-1:0] nxt;
  assign nxt = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count   <= '0;
      ovf_evt <= 1'b0;
      dly_evt <= 1'b0;
    end else begin
      ovf_evt <= 1'b0;
      dly_evt <= 1'b0;
      if (reload) begin
        count <= load_val;
      end else if (step) begin
        if (&count) begin
          count   <= load_val;
          ovf_evt <= 1'b1;
        end else begin
          count   <= nxt;
          dly_evt <= (nxt == delay_val);
        end
      end
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdt_pkg::*;
#(
  parameter int          CNT_W  = 32,
  parameter int          PTV_W  = 3,
  parameter logic [31:0] REV_ID = 32'h0000_5A31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             rst_req
);
  localparam int PS_W = PTV_W + 1;

  logic             wr;
  logic             srst_pend, srst_now;
  logic [NPEND-1:0] pend;
  logic [PS_W-1:0]  sh_presc, presc_r;
  logic [CNT_W-1:0] sh_load, load_r, sh_trig, trig_r, sh_delay, delay_r;
  logic [31:0]      sh_key;
  logic [1:0]       istat, ien, clr_mask;
  logic             running, reload, step, ovf_evt, dly_evt;
  logic [CNT_W-1:0] load_next, count;

  assign wr        = bus_sel && bus_we;
  assign srst_now  = slow_tick && srst_pend;
  assign reload    = slow_tick && pend[P_TRIG] && (sh_trig != trig_r);
  assign load_next = (slow_tick && pend[P_LOAD]) ? sh_load : load_r;
  assign clr_mask  = (wr && bus_addr == RA_ISTAT) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n || srst_now) begin
      srst_pend <= 1'b0;
      pend      <= '0;
      sh_presc  <= '0;
      presc_r   <= '0;
      sh_load   <= '0;
      load_r    <= '0;
      sh_trig   <= '0;
      trig_r    <= '0;
      sh_delay  <= '0;
      delay_r   <= '0;
      sh_key    <= '0;
      istat     <= '0;
      ien       <= '0;
    end else begin
      if (slow_tick) begin
        if (pend[P_PRESC]) presc_r <= sh_presc;
        if (pend[P_LOAD])  load_r  <= sh_load;
        if (pend[P_TRIG])  trig_r  <= sh_trig;
        if (pend[P_DELAY]) delay_r <= sh_delay;
        pend <= '0;
      end
      if (wr) begin
        case (bus_addr)
          RA_SYSCTL: if (bus_wdata[0]) srst_pend <= 1'b1;
          RA_IEN:    ien <= bus_wdata[1:0];
          RA_PRESC:  if (!pend[P_PRESC]) begin
                       sh_presc <= bus_wdata[PS_W-1:0];
                       pend[P_PRESC] <= 1'b1;
                     end
          RA_LOAD:   if (!pend[P_LOAD]) begin
                       sh_load <= bus_wdata[CNT_W-1:0];
                       pend[P_LOAD] <= 1'b1;
                     end
          RA_TRIG:   if (!pend[P_TRIG]) begin
                       sh_trig <= bus_wdata[CNT_W-1:0];
                       pend[P_TRIG] <= 1'b1;
                     end
          RA_DELAY:  if (!pend[P_DELAY]) begin
                       sh_delay <= bus_wdata[CNT_W-1:0];
                       pend[P_DELAY] <= 1'b1;
                     end
          RA_KEY:    if (!pend[P_KEY]) begin
                       sh_key <= bus_wdata;
                       pend[P_KEY] <= 1'b1;
                     end
          default: ;
        endcase
      end
      istat <= (istat & ~clr_mask) | {dly_evt, ovf_evt};
    end
  end

  wdt_keyfsm u_key (
    .clk(clk), .rst_n(rst_n), .clr(srst_now),
    .apply(slow_tick && pend[P_KEY]), .word(sh_key), .running(running)
  );

  wdt_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(srst_now || reload), .tick(slow_tick),
    .run(running), .pre_en(presc_r[PTV_W]), .ptv(presc_r[PTV_W-1:0]),
    .step(step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(srst_now), .reload(reload),
    .load_val(load_next), .step(step), .delay_val(delay_r),
    .count(count), .ovf_evt(ovf_evt), .dly_evt(dly_evt)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_ID:     bus_rdata = REV_ID;
      RA_SYSCTL: bus_rdata[0] = srst_pend;
      RA_ISTAT:  bus_rdata[1:0] = istat;
      RA_IEN:    bus_rdata[1:0] = ien;
      RA_PRESC:  bus_rdata[PS_W-1:0] = presc_r;
      RA_COUNT:  bus_rdata[CNT_W-1:0] = count;
      RA_LOAD:   bus_rdata[CNT_W-1:0] = load_r;
      RA_TRIG:   bus_rdata[CNT_W-1:0] = trig_r;
      RA_PEND:   bus_rdata[NPEND-1:0] = pend;
      RA_DELAY:  bus_rdata[CNT_W-1:0] = delay_r;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq     = |(istat & ien);
  assign rst_req = ovf_evt;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [NPEND-1:0] pend,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             rst_req,
  input logic [1:0]       istat
);
  assert_count_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(count));

  assert_run_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(running));

  assert_pend_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !(bus_sel && bus_we)) |=> (pend == '0));

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_ovf_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !slow_tick) |=> istat[0]);
endmodule

bind wdog_keyed wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
  .bus_we(bus_we), .pend(pend), .count(count), .running(running),
  .rst_req(rst_req), .istat(istat)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam logic [31:0] REV = 32'h0000_5A31;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  localparam logic [3:0] I_ID = 4'd0, I_CTL = 4'd1, I_ST = 4'd2, I_EN = 4'd3,
    I_PS = 4'd4, I_CNT = 4'd5, I_LD = 4'd6, I_TG = 4'd7, I_PD = 4'd8,
    I_DL = 4'd9, I_KEY = 4'd10;
  localparam int NV = 36;
  // {op, requirement number, index, data}
  localparam logic [41:0] VEC [NV] = '{
    {OP_RD, 4'd12, I_ID,  REV},            // R12 id
    {OP_RD, 4'd1,  I_PD,  32'h0},          // R1
    {OP_RD, 4'd1,  I_CNT, 32'h0},          // R1
    {OP_WR, 4'd2,  I_KEY, 32'hBBBB},       // R2 first key
    {OP_RD, 4'd5,  I_PD,  32'h10},         // R5 key pending
    {OP_WR, 4'd5,  I_KEY, 32'h4444},       // R5 dropped
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd5,  I_PD,  32'h0},          // R5 cleared
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd2,  I_CNT, 32'h0},          // R2 not yet running
    {OP_WR, 4'd2,  I_KEY, 32'h4444},
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd2,  I_CNT, 32'h0},          // R2
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd2,  I_CNT, 32'h1},          // R2
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd2,  I_CNT, 32'h3},          // R2
    {OP_WR, 4'd4,  I_KEY, 32'hAAAA},       // R4 broken sequence
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_WR, 4'd4,  I_KEY, 32'h1234},
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_WR, 4'd4,  I_KEY, 32'h5555},
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd4,  I_CNT, 32'h6},          // R4 still running
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd4,  I_CNT, 32'h7},          // R4
    {OP_WR, 4'd3,  I_KEY, 32'hAAAA},       // R3 proper stop
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_WR, 4'd3,  I_KEY, 32'h5555},
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_TK, 4'd0,  4'd0,  32'h0},
    {OP_RD, 4'd3,  I_CNT, 32'h9},          // R3 held
    {OP_WR, 4'd12, I_ID,  32'hFFFF},       // R12 write ignored
    {OP_RD, 4'd12, I_ID,  REV},            // R12
    {OP_RD, 4'd5,  I_PD,  32'h0}           // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, rst_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wdog_keyed dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int req, input logic [3:0] a, input logic [31:0] exp);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(1, {30'b0, irq, rst_req}, 32'h0);  // R1 outputs low

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][41:40])
        OP_WR: wr(VEC[v][35:32], VEC[v][31:0]);
        OP_RD: rd(int'(VEC[v][39:36]), VEC[v][35:32], VEC[v][31:0]);
        default: tk(1);
      endcase
    end

    // R7 changed trigger with same-tick load
    wr(I_LD, 32'hFFFF_FFFE);
    wr(I_TG, 32'h1);
    rd(5, I_PD, 32'h6);                      // R5 load+trigger pending
    tk(1);
    rd(7, I_CNT, 32'hFFFF_FFFE);             // R7
    wr(I_EN, 32'h3);
    wr(I_KEY, 32'hBBBB); tk(1);
    wr(I_KEY, 32'h4444); tk(1);
    tk(1);
    rd(6, I_CNT, 32'hFFFF_FFFF);
    // R6 overflow
    tk(1);
    #1 chk(6, {31'b0, rst_req}, 32'h1);      // R6 pulse
    rd(6, I_CNT, 32'hFFFF_FFFE);             // R6 reload
    @(negedge clk);
    #1 chk(6, {31'b0, rst_req}, 32'h0);      // R6 one clock only
    chk(10, {31'b0, irq}, 32'h1);            // R10
    rd(6, I_ST, 32'h1);                      // R6 status
    wr(I_ST, 32'h1);
    rd(10, I_ST, 32'h0);                     // R10 w1c
    #1 chk(10, {31'b0, irq}, 32'h0);

    // R7 equal trigger: no reload
    wr(I_TG, 32'h1); tk(1);
    rd(7, I_CNT, 32'hFFFF_FFFF);
    wr(I_TG, 32'h2); tk(1);
    #1 chk(7, {31'b0, rst_req}, 32'h0);
    rd(7, I_CNT, 32'hFFFF_FFFE);

    // R9 delay match
    wr(I_DL, 32'h10); wr(I_LD, 32'h0); wr(I_TG, 32'h3);
    tk(1);
    rd(9, I_CNT, 32'h0);
    tk(15);
    rd(9, I_ST, 32'h0);
    tk(1);
    @(negedge clk);
    rd(9, I_ST, 32'h2);                      // R9
    #1 chk(10, {31'b0, irq}, 32'h1);         // R10
    wr(I_ST, 32'h2);

    // R8 prescaler P=1
    wr(I_PS, 32'h9); tk(1);
    rd(8, I_CNT, 32'h11);
    tk(1); rd(8, I_CNT, 32'h11);
    tk(1); rd(8, I_CNT, 32'h12);
    tk(2); rd(8, I_CNT, 32'h13);

    // R11 soft reset
    wr(I_CTL, 32'h1);
    rd(11, I_CTL, 32'h1);
    tk(1);
    rd(11, I_CTL, 32'h0);
    rd(11, I_CNT, 32'h0);
    rd(11, I_LD, 32'h0);
    rd(11, I_PS, 32'h0);
    rd(11, I_EN, 32'h0);
    tk(2);
    rd(11, I_CNT, 32'h0);                    // R11 stopped after reset
    #1 chk(11, {31'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule